// File: doc/BRIEF.md
# Rotation-Keyed Serial Byte Transmitter

This block is the sending half of a small modem link. A user presents three nibbles in turn on one shared 4-bit input, each framed by its own request/acknowledge exchange. The first nibble is a rotation key. The second is the low half of a data byte and the third is the high half. Once the byte is assembled, the block scrambles it by rotating the whole byte right, one position per clock, until a step counter matches the key. It then shifts the byte out least significant bit first on a single data line. Every bit is framed by a four-phase request/acknowledge exchange with the receiver.

The user-facing strobe, the nibble lines and the receiver acknowledge all pass through a two-stage flip-flop synchronizer before the controller sees them. A select input chooses which half of the internal byte register appears on a 4-bit view output. When a byte has been fully sent, the block waits for a new low nibble and keeps the stored key, so no new key is needed.

The controller states are:
- KEY_WAIT goes to KEY_ACK on a high strobe and captures the key.
- KEY_ACK goes to LO_WAIT on a low strobe.
- LO_WAIT goes to LO_ACK on a high strobe and captures the low nibble.
- LO_ACK goes to HI_WAIT on a low strobe.
- HI_WAIT goes to HI_ACK on a high strobe and captures the high nibble.
- HI_ACK goes to ROTATE on a low strobe.
- ROTATE rotates once per cycle until the count equals the key, then goes to BIT_LOAD.
- BIT_LOAD copies bit 0 to the line, rotates once, counts the bit, then goes to BIT_REQ.
- BIT_REQ goes to BIT_DROP on a high acknowledge.
- BIT_DROP, on a low acknowledge, goes to LO_WAIT after eight bits and to BIT_LOAD otherwise.

Top module: `rot_serial_sender`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to KEY_WAIT. After reset, `tx_req`, `nib_ack` and `key_ready` are all 0.
- R2: Nibbles are taken in the order key, low, high. `nib_ack` rises only after a high `nib_strobe` has been seen and falls only after a low `nib_strobe` has been seen.
- R3: `key_ready` goes to 1 once the key handshake completes and stays at 1 until reset.
- R4: The byte {high, low} is rotated right by the key value modulo 8. Only key bits 2:0 count, so key 10 rotates by 2 and key 8 rotates by 0.
- R5: The scrambled byte is sent least significant bit first. Each bit is on `tx_data` when `tx_req` rises.
- R6: Once `tx_req` is high, it stays high until the acknowledge is seen high. `tx_data` holds steady while `tx_req` is high.
- R7: After `tx_req` falls, it does not rise again until `tx_ack` has been seen low.
- R8: After exactly eight bits, the block accepts a new low nibble and reuses the stored key without a new key handshake.
- R9: When `view_hi` is 1, `view_nib` shows bits 7:4 of the byte register. When it is 0, `view_nib` shows bits 3:0. After a full send, the register again holds the scrambled byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_in | input | 4 | Shared nibble input for the key and the data halves |
| nib_strobe | input | 1 | User request: `nib_in` is valid |
| nib_ack | output | 1 | Nibble acknowledge to the user |
| key_ready | output | 1 | Key has been captured |
| tx_data | output | 1 | Serial data line |
| tx_req | output | 1 | Bit request to the receiver |
| tx_ack | input | 1 | Bit acknowledge from the receiver |
| view_hi | input | 1 | Selects the upper nibble for viewing |
| view_nib | output | 4 | Viewed nibble of the byte register |

## Verification
The assertions assume that the user holds `nib_in` steady from before `nib_strobe` rises until `nib_ack` is seen. They also assume that the receiver raises `tx_ack` only in answer to `tx_req` and lowers it only after `tx_req` has fallen. The bench keeps within these limits by driving both sides as handshake tasks that wait on the block's outputs at falling edges. In some runs it holds an acknowledge phase for many extra cycles. The keys 0, 3, 8, 10 and 15 cover the modulo-8 folding of the key, and one reset is applied in the middle of operation.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [3:0] {
        ST_KEY_WAIT,
        ST_KEY_ACK,
        ST_LO_WAIT,
        ST_LO_ACK,
        ST_HI_WAIT,
        ST_HI_ACK,
        ST_ROTATE,
        ST_BIT_LOAD,
        ST_BIT_REQ,
        ST_BIT_DROP
    } tx_state_t;
endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rss_counter.sv
module rss_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    assign hit = (count == limit);

    // R8 / R4: the controller never steps past the compare value
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> !hit);
endmodule

// File: rtl/rss_datapath.sv
module rss_datapath #(
    parameter int NIB_W = 4,
    parameter int RW    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NIB_W-1:0]   nib,
    input  logic               ld_key,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic               rot,
    input  logic               emit,
    input  logic               view_hi,
    output logic [RW-1:0]      key,
    output logic               tx_bit,
    output logic [NIB_W-1:0]   view_nib
);
    localparam int BW = 2 * NIB_W;
    logic [BW-1:0] data;

    always_ff @(posedge clk) begin
        if (rst) begin
            key    <= '0;
            data   <= '0;
            tx_bit <= 1'b0;
        end else begin
            if (ld_key) key <= nib[RW-1:0];
            if (ld_lo)  data[NIB_W-1:0] <= nib;
            if (ld_hi)  data[BW-1:NIB_W] <= nib;
            if (rot)    data <= {data[0], data[BW-1:1]};
            if (emit)   tx_bit <= data[0];
        end
    end

    assign view_nib = view_hi ? data[BW-1:NIB_W] : data[NIB_W-1:0];

    // R4: a single-step rotation keeps the bit population
    assert_rot_keeps_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (rot && !ld_lo && !ld_hi) |=> ($countones(data) == $countones($past(data))));
endmodule

// File: rtl/rss_ctrl.sv
module rss_ctrl
    import rss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strb_s,
    input  logic ack_s,
    input  logic rot_hit,
    input  logic send_hit,
    output logic ld_key,
    output logic ld_lo,
    output logic ld_hi,
    output logic rot,
    output logic emit,
    output logic rot_clr,
    output logic rot_inc,
    output logic send_clr,
    output logic send_inc,
    output logic nib_ack,
    output logic key_ready,
    output logic tx_req
);
    tx_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_KEY_WAIT;
        else     state <= nxt;
    end

    always_comb begin
        nxt       = state;
        ld_key    = 1'b0;
        ld_lo     = 1'b0;
        ld_hi     = 1'b0;
        rot       = 1'b0;
        emit      = 1'b0;
        rot_clr   = 1'b1;
        rot_inc   = 1'b0;
        send_clr  = 1'b0;
        send_inc  = 1'b0;
        nib_ack   = 1'b0;
        key_ready = 1'b1;
        tx_req    = 1'b0;
        unique case (state)
            ST_KEY_WAIT: begin
                key_ready = 1'b0;
                if (strb_s) begin ld_key = 1'b1; nxt = ST_KEY_ACK; end
            end
            ST_KEY_ACK: begin
                key_ready = 1'b0;
                nib_ack   = 1'b1;
                if (!strb_s) nxt = ST_LO_WAIT;
            end
            ST_LO_WAIT: begin
                if (strb_s) begin ld_lo = 1'b1; nxt = ST_LO_ACK; end
            end
            ST_LO_ACK: begin
                nib_ack = 1'b1;
                if (!strb_s) nxt = ST_HI_WAIT;
            end
            ST_HI_WAIT: begin
                if (strb_s) begin ld_hi = 1'b1; nxt = ST_HI_ACK; end
            end
            ST_HI_ACK: begin
                nib_ack = 1'b1;
                if (!strb_s) nxt = ST_ROTATE;
            end
            ST_ROTATE: begin
                rot_clr  = 1'b0;
                send_clr = 1'b1;
                if (rot_hit) nxt = ST_BIT_LOAD;
                else begin rot = 1'b1; rot_inc = 1'b1; end
            end
            ST_BIT_LOAD: begin
                emit     = 1'b1;
                rot      = 1'b1;
                send_inc = 1'b1;
                nxt      = ST_BIT_REQ;
            end
            ST_BIT_REQ: begin
                tx_req = 1'b1;
                if (ack_s) nxt = ST_BIT_DROP;
            end
            ST_BIT_DROP: begin
                if (!ack_s) nxt = send_hit ? ST_LO_WAIT : ST_BIT_LOAD;
            end
            default: nxt = ST_KEY_WAIT;
        endcase
    end

    // R6: request held until the acknowledge is seen
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !ack_s) |=> tx_req);
    // R7: no new request while the acknowledge is still high
    assert_four_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (!tx_req && ack_s) |=> !tx_req);
    // R3: ready flag is sticky
    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        key_ready |=> key_ready);
    // R2: acknowledge only answers a strobe
    assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_ack) |-> $past(strb_s));
    // R2: acknowledge released only after strobe drops
    assert_ack_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(nib_ack) |-> !$past(strb_s));
endmodule

// File: rtl/rot_serial_sender.sv
module rot_serial_sender #(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             nib_strobe,
    output logic             nib_ack,
    output logic             key_ready,
    output logic             tx_data,
    output logic             tx_req,
    input  logic             tx_ack,
    input  logic             view_hi,
    output logic [NIB_W-1:0] view_nib
);
    localparam int BW = 2 * NIB_W;
    localparam int RW = $clog2(BW);
    localparam int SW = RW + 1;
    localparam logic [SW-1:0] SEND_LIMIT = SW'(BW);

    logic [NIB_W+1:0] raw_in, syn_out;
    logic [NIB_W-1:0] nib_s;
    logic strb_s, ack_s;

    assign raw_in = {tx_ack, nib_strobe, nib_in};
    assign {ack_s, strb_s, nib_s} = syn_out;

    rss_sync #(.W(NIB_W + 2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn_out)
    );

    logic ld_key, ld_lo, ld_hi, rot, emit;
    logic rot_clr, rot_inc, send_clr, send_inc;
    logic rot_hit, send_hit;
    logic [RW-1:0] key, rot_cnt;
    logic [SW-1:0] send_cnt;

    rss_counter #(.W(RW)) u_rot_cnt (
        .clk(clk), .rst(rst), .clr(rot_clr), .inc(rot_inc),
        .limit(key), .count(rot_cnt), .hit(rot_hit)
    );

    rss_counter #(.W(SW)) u_send_cnt (
        .clk(clk), .rst(rst), .clr(send_clr), .inc(send_inc),
        .limit(SEND_LIMIT), .count(send_cnt), .hit(send_hit)
    );

    rss_datapath #(.NIB_W(NIB_W), .RW(RW)) u_dp (
        .clk(clk), .rst(rst), .nib(nib_s),
        .ld_key(ld_key), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .rot(rot), .emit(emit), .view_hi(view_hi),
        .key(key), .tx_bit(tx_data), .view_nib(view_nib)
    );

    rss_ctrl u_ctrl (
        .clk(clk), .rst(rst), .strb_s(strb_s), .ack_s(ack_s),
        .rot_hit(rot_hit), .send_hit(send_hit),
        .ld_key(ld_key), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .rot(rot), .emit(emit),
        .rot_clr(rot_clr), .rot_inc(rot_inc),
        .send_clr(send_clr), .send_inc(send_inc),
        .nib_ack(nib_ack), .key_ready(key_ready), .tx_req(tx_req)
    );

    // R6: serial data steady while a request is up
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && $past(tx_req)) |-> $stable(tx_data));
    // R8: at most the byte width of bits per byte
    assert_send_bound_R8: assert property (@(posedge clk) disable iff (rst)
        send_cnt <= SEND_LIMIT);
    // R4: rotation counter stays within the folded key
    assert_rot_bound_R4: assert property (@(posedge clk) disable iff (rst)
        rot_inc |-> (rot_cnt != key));
endmodule

// File: tb/sim_rot_serial_sender.sv
module sim_rot_serial_sender;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib_in = '0;
    logic       nib_strobe = 1'b0;
    logic       tx_ack = 1'b0;
    logic       view_hi = 1'b0;
    logic       nib_ack, key_ready, tx_data, tx_req;
    logic [3:0] view_nib;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    rot_serial_sender u0 (
        .clk(clk), .rst(rst), .nib_in(nib_in), .nib_strobe(nib_strobe),
        .nib_ack(nib_ack), .key_ready(key_ready), .tx_data(tx_data),
        .tx_req(tx_req), .tx_ack(tx_ack), .view_hi(view_hi), .view_nib(view_nib)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_sig(ref logic s, input logic v);
        while (s !== v) @(negedge clk);
    endtask

    function automatic logic [7:0] ror8(input logic [7:0] b, input int k);
        logic [15:0] t;
        t = {b, b} >> (k % 8);
        return t[7:0];
    endfunction

    task automatic give_nibble(input logic [3:0] v);
        @(negedge clk);
        nib_in = v;
        nib_strobe = 1'b1;
        wait_sig(nib_ack, 1'b1);
        check("R2 ack while strobe high", nib_strobe, 1);
        nib_strobe = 1'b0;
        wait_sig(nib_ack, 1'b0);
        @(negedge clk);
    endtask

    task automatic take_byte(output logic [7:0] got, input int hold);
        for (int i = 0; i < 8; i++) begin
            wait_sig(tx_req, 1'b1);
            got[i] = tx_data;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check("R6 req held without ack", tx_req, 1);
                check("R6 data stable", tx_data, got[i]);
            end
            tx_ack = 1'b1;
            wait_sig(tx_req, 1'b0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check("R7 no req while ack high", tx_req, 0);
            end
            tx_ack = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx_req after reset", tx_req, 0);
        check("R1 nib_ack after reset", nib_ack, 0);
        check("R1 key_ready after reset", key_ready, 0);
    endtask

    task automatic run_byte(input bit load_key, input logic [3:0] k,
                            input logic [7:0] b, input int hold);
        logic [7:0] got, exp;
        if (load_key) begin
            give_nibble(k);
            check("R3 key_ready after key", key_ready, 1);
        end
        give_nibble(b[3:0]);
        view_hi = 1'b0;
        #1 check("R9 view low after load", view_nib, b[3:0]);
        give_nibble(b[7:4]);
        take_byte(got, hold);
        exp = ror8(b, k);
        check("R4 R5 serial byte", got, exp);
        repeat (8) @(negedge clk);
        view_hi = 1'b0;
        #1 check("R9 view low after send", view_nib, exp[3:0]);
        view_hi = 1'b1;
        #1 check("R9 view high after send", view_nib, exp[7:4]);
        check("R3 key_ready held", key_ready, 1);
        check("R8 no req idle", tx_req, 0);
    endtask

    task automatic test_basic();
        run_byte(1'b1, 4'd3, 8'hB4, 0);
    endtask

    task automatic test_key_reuse_R8();
        run_byte(1'b0, 4'd3, 8'h5C, 0);
    endtask

    task automatic test_fold_R4();
        do_reset();
        run_byte(1'b1, 4'd10, 8'h81, 2);
        do_reset();
        run_byte(1'b1, 4'd8, 8'h37, 0);
        do_reset();
        run_byte(1'b1, 4'd15, 8'hE2, 0);
        do_reset();
        run_byte(1'b1, 4'd0, 8'hA6, 3);
    endtask

    task automatic test_mid_reset_R1();
        give_nibble(4'd5);
        give_nibble(4'h9);
        do_reset();
        run_byte(1'b1, 4'd1, 8'h0F, 0);
    endtask

    initial begin
        do_reset();
        test_basic();
        test_key_reuse_R8();
        test_fold_R4();
        test_mid_reset_R1();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule